// File: doc/BRIEF.md
# Bit-Node Processor Sequencer

This block drives one bit-node processor of an iterative low-density parity-check decoder. It does not touch message values. It produces the strobes and addresses around the processor's memories: a write port into the incoming-message RAM, a read address for the channel-measurement RAM, and a read address for a small degree RAM that holds how many edges each bit node has. In the sending and final phases it walks the bit nodes in order. At the start of each node it loads the node's first-edge address and edge count into the adder's operand store. It then steps one edge per cycle and tells the adder which input to leave out, so that each outgoing message is extrinsic.

A main decoder controller selects the phase through a two-bit mode input. In the first iteration the message RAM holds nothing valid yet, so the sequencer steers a multiplexer that feeds the channel value in its place. In the final phase every adder input stays enabled, so the sum is the full posterior used for the hard decision. The adder needs a fixed number of cycles to produce a result, so every issued output slot reappears on a tagged result strobe after that pipeline delay.

Top module: `bn_seq_ctrl`

## Requirements
- R1: In receive mode (mode = 1), `msg_we` follows `msg_in_vld` in the same cycle. `msg_waddr` starts at 0 and advances by one after each accepted write. In any other mode `msg_we` stays 0 whatever `msg_in_vld` does.
- R2: Idle mode (mode = 0) returns the write address to 0, so a later receive phase starts writing at address 0.
- R3: After mode changes from idle to send (2) or final (3), exactly one priming cycle with `sweep_act` = 0 comes before node 0 starts. `deg_raddr` reads 0 outside active cycles. While node n is active it reads n+1, and it reads 0 while the last node is active.
- R4: Node n stays active for d(n) cycles and issues edges 0 to d(n)-1 in order. Nodes follow each other in increasing order from 0 to NODES-1. Here d(n) is the degree RAM word for node n, forced to 2 when it is below 2 and to DMAX when it is above DMAX.
- R5: `opnd_ld` pulses only on the first cycle of each node. With it, `opnd_base` carries the sum of d(k) over all earlier nodes k, and `opnd_cnt` carries d(n).
- R6: While a node is active, `chan_raddr` equals that node's index.
- R7: In send mode, `in_dis` has exactly bit e set during the cycle that issues edge e. Outside active cycles `in_dis` is 0.
- R8: `chan_bypass` is 1 only in active send-mode cycles while `first_iter` is 1. It stays 0 in final mode, even with `first_iter` set.
- R9: In final mode, `in_dis` is 0 on every cycle. Each node produces a single result, tagged `res_post` = 1, on its last edge cycle.
- R10: In send mode every active cycle produces a result. Each result (node, edge, post flag) appears on `res_*` with `res_vld` exactly LAT cycles after the cycle that issued it.
- R11: After the last edge of the last node, `sweep_done` rises and stays 1 with no further activity until mode returns to idle. It falls one cycle after that.
- R12: After reset, every strobe and the done flag are 0, and the write and degree addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 idle, 1 receive, 2 send, 3 final |
| first_iter | input | 1 | First decoding iteration, message RAM not yet valid |
| msg_in_vld | input | 1 | An incoming message is present this cycle |
| msg_we | output | 1 | Message RAM write enable |
| msg_waddr | output | BASE_W | Message RAM write address |
| deg_raddr | output | NODE_W | Degree RAM read address (one-cycle synchronous read) |
| deg_rdata | input | DEG_W | Degree RAM read data |
| chan_raddr | output | NODE_W | Channel-measurement RAM address |
| opnd_ld | output | 1 | Load operand store with a new node's edges |
| opnd_base | output | BASE_W | First edge address of the node being loaded |
| opnd_cnt | output | DEG_W | Edge count of the node being loaded |
| in_dis | output | DMAX | Per-input adder disable, bit e is edge e |
| chan_bypass | output | 1 | Select channel value in place of message RAM data |
| sweep_act | output | 1 | A node edge is issued this cycle |
| sweep_done | output | 1 | All nodes of the current sweep issued |
| res_vld | output | 1 | Adder result available |
| res_post | output | 1 | Result is a final-mode posterior |
| res_node | output | NODE_W | Node index of the result |
| res_edge | output | EDGE_W | Edge index of the result |

## Verification
The hardest case to reach is a node with the minimum degree of two. Its successor's degree must already be on the degree RAM output by its second and last cycle, so the one-cycle read-ahead has no slack. Nodes of extreme degree must also go through the clamp. The bench reaches this by loading the modelled degree RAM with degree patterns that contain back-to-back two-edge nodes, out-of-range words (0, 1, 9, 15) and a full-width node. It runs full send and final sweeps over those patterns and scores every operand load, every active cycle and every delayed result against a queue built from the clamped degrees.

// File: rtl/bnc_pkg.sv
package bnc_pkg;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_RECV  = 2'd1,
        MD_SEND  = 2'd2,
        MD_FINAL = 2'd3
    } bnc_mode_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_PRIME,
        SW_RUN,
        SW_DONE
    } sweep_st_e;

endpackage

// File: rtl/bnc_wptr.sv
// Write pointer for the incoming-message RAM.
module bnc_wptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr)
            addr_d = '0;
        else if (wr)
            addr_d = addr_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/bnc_sweep.sv
// Node/edge walker with one-cycle degree read-ahead.
module bnc_sweep
    import bnc_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int DMAX   = 8,
    parameter int NODE_W = 3,
    parameter int EDGE_W = 3,
    parameter int DEG_W  = 4,
    parameter int BASE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DEG_W-1:0]  deg_rdata,
    output logic              act,
    output logic              done,
    output logic              first,
    output logic              last,
    output logic [NODE_W-1:0] node,
    output logic [NODE_W-1:0] deg_raddr,
    output logic [EDGE_W-1:0] edge_idx,
    output logic [BASE_W-1:0] base,
    output logic [DEG_W-1:0]  deg
);
    typedef struct packed {
        sweep_st_e         st;
        logic [NODE_W-1:0] node;
        logic [EDGE_W-1:0] edg;
        logic [BASE_W-1:0] base;
        logic [DEG_W-1:0]  deg;
    } sw_t;

    localparam sw_t SW_RST = '{st: SW_IDLE, node: '0, edg: '0, base: '0, deg: '0};
    localparam logic [NODE_W-1:0] LAST_NODE = NODE_W'(NODES - 1);

    sw_t sw_d, sw_q;
    logic edge_last;

    function automatic logic [DEG_W-1:0] clamp_deg(input logic [DEG_W-1:0] d);
        if (d < DEG_W'(2))
            return DEG_W'(2);
        if (d > DEG_W'(DMAX))
            return DEG_W'(DMAX);
        return d;
    endfunction

    assign edge_last = (DEG_W'(sw_q.edg) == (sw_q.deg - DEG_W'(1)));

    always_comb begin
        sw_d = sw_q;
        unique case (sw_q.st)
            SW_IDLE: begin
                sw_d = SW_RST;
                if (go)
                    sw_d.st = SW_PRIME;
            end
            SW_PRIME: begin
                sw_d.st  = SW_RUN;
                sw_d.deg = clamp_deg(deg_rdata);
            end
            SW_RUN: begin
                if (edge_last) begin
                    if (sw_q.node == LAST_NODE) begin
                        sw_d.st = SW_DONE;
                    end else begin
                        sw_d.node = sw_q.node + NODE_W'(1);
                        sw_d.edg  = '0;
                        sw_d.base = sw_q.base + BASE_W'(sw_q.deg);
                        sw_d.deg  = clamp_deg(deg_rdata);
                    end
                end else begin
                    sw_d.edg = sw_q.edg + EDGE_W'(1);
                end
            end
            SW_DONE: sw_d.st = SW_DONE;
            default: sw_d = SW_RST;
        endcase
        if (!go)
            sw_d = SW_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_q <= SW_RST;
        else
            sw_q <= sw_d;
    end

    assign act       = (sw_q.st == SW_RUN);
    assign done      = (sw_q.st == SW_DONE);
    assign first     = act && (sw_q.edg == '0);
    assign last      = act && edge_last;
    assign node      = sw_q.node;
    assign edge_idx  = sw_q.edg;
    assign base      = sw_q.base;
    assign deg       = sw_q.deg;
    assign deg_raddr = !act ? '0 :
                       (sw_q.node == LAST_NODE) ? '0 : sw_q.node + NODE_W'(1);
endmodule

// File: rtl/bnc_mask.sv
// Adder input disable decoder.
module bnc_mask #(
    parameter int DMAX   = 8,
    parameter int EDGE_W = 3
) (
    input  logic              en,
    input  logic              all_in,
    input  logic [EDGE_W-1:0] edge_idx,
    output logic [DMAX-1:0]   dis
);
    for (genvar g = 0; g < DMAX; g++) begin : g_in
        assign dis[g] = en && !all_in && (edge_idx == EDGE_W'(g));
    end
endmodule

// File: rtl/bnc_pipe.sv
// Fixed-latency tag pipeline matching the adder's delay.
module bnc_pipe #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stg
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg_q[0] <= '0;
                else
                    stg_q[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg_q[g] <= '0;
                else
                    stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign dout = stg_q[LAT-1];
endmodule

// File: rtl/bn_seq_ctrl.sv
module bn_seq_ctrl
    import bnc_pkg::*;
#(
    parameter  int NODES  = 8,
    parameter  int DMAX   = 8,
    parameter  int LAT    = 3,
    localparam int NODE_W = $clog2(NODES),
    localparam int EDGE_W = $clog2(DMAX),
    localparam int DEG_W  = $clog2(DMAX + 1),
    localparam int BASE_W = $clog2(NODES * DMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              first_iter,
    input  logic              msg_in_vld,
    output logic              msg_we,
    output logic [BASE_W-1:0] msg_waddr,
    output logic [NODE_W-1:0] deg_raddr,
    input  logic [DEG_W-1:0]  deg_rdata,
    output logic [NODE_W-1:0] chan_raddr,
    output logic              opnd_ld,
    output logic [BASE_W-1:0] opnd_base,
    output logic [DEG_W-1:0]  opnd_cnt,
    output logic [DMAX-1:0]   in_dis,
    output logic              chan_bypass,
    output logic              sweep_act,
    output logic              sweep_done,
    output logic              res_vld,
    output logic              res_post,
    output logic [NODE_W-1:0] res_node,
    output logic [EDGE_W-1:0] res_edge
);
    localparam int TAG_W = 2 + NODE_W + EDGE_W;

    bnc_mode_e         md;
    logic              is_recv, is_send, is_final, go;
    logic              act, done, first, last;
    logic [NODE_W-1:0] node;
    logic [EDGE_W-1:0] edge_idx;
    logic [BASE_W-1:0] base;
    logic [DEG_W-1:0]  deg;
    logic              issue;
    logic [TAG_W-1:0]  tag_in, tag_out;

    assign md       = bnc_mode_e'(mode);
    assign is_recv  = (md == MD_RECV);
    assign is_send  = (md == MD_SEND);
    assign is_final = (md == MD_FINAL);
    assign go       = is_send || is_final;

    assign msg_we = is_recv && msg_in_vld;

    bnc_wptr #(.AW(BASE_W)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (md == MD_IDLE),
        .wr    (msg_we),
        .addr  (msg_waddr)
    );

    bnc_sweep #(
        .NODES  (NODES),
        .DMAX   (DMAX),
        .NODE_W (NODE_W),
        .EDGE_W (EDGE_W),
        .DEG_W  (DEG_W),
        .BASE_W (BASE_W)
    ) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .deg_rdata (deg_rdata),
        .act       (act),
        .done      (done),
        .first     (first),
        .last      (last),
        .node      (node),
        .deg_raddr (deg_raddr),
        .edge_idx  (edge_idx),
        .base      (base),
        .deg       (deg)
    );

    bnc_mask #(.DMAX(DMAX), .EDGE_W(EDGE_W)) u_mask (
        .en       (act),
        .all_in   (is_final),
        .edge_idx (edge_idx),
        .dis      (in_dis)
    );

    assign chan_raddr  = act ? node : '0;
    assign opnd_ld     = first;
    assign opnd_base   = first ? base : '0;
    assign opnd_cnt    = first ? deg : '0;
    assign chan_bypass = act && is_send && first_iter;
    assign sweep_act   = act;
    assign sweep_done  = done;

    assign issue  = act && (is_send || last);
    assign tag_in = {issue, is_final, node, edge_idx};

    bnc_pipe #(.W(TAG_W), .LAT(LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tag_in),
        .dout  (tag_out)
    );

    assign res_vld  = tag_out[TAG_W-1];
    assign res_post = res_vld && tag_out[TAG_W-2];
    assign res_node = res_vld ? tag_out[EDGE_W +: NODE_W] : '0;
    assign res_edge = res_vld ? tag_out[EDGE_W-1:0] : '0;
endmodule

// File: rtl/bn_seq_ctrl_chk.sv
module bn_seq_ctrl_chk #(
    parameter int NODE_W = 3,
    parameter int DEG_W  = 4,
    parameter int BASE_W = 7,
    parameter int DMAX   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              msg_we,
    input logic [BASE_W-1:0] msg_waddr,
    input logic [NODE_W-1:0] deg_raddr,
    input logic [NODE_W-1:0] chan_raddr,
    input logic              opnd_ld,
    input logic [DMAX-1:0]   in_dis,
    input logic              chan_bypass,
    input logic              sweep_act,
    input logic              sweep_done
);
    AST_WE_RECV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_we |-> mode == 2'd1);  // R1

    AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        msg_we |=> (mode != 2'd1) || (msg_waddr == BASE_W'($past(msg_waddr) + 1'b1)));  // R1

    AST_DEG_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_act |-> deg_raddr == '0);  // R3

    AST_LOAD_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_ld |-> sweep_act);  // R5

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_act && !opnd_ld) |-> $stable(chan_raddr));  // R6

    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_dis));  // R7

    AST_BYPASS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        chan_bypass |-> (sweep_act && mode == 2'd2));  // R8

    AST_FINAL_ALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> in_dis == '0);  // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> !sweep_act);  // R11

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done && mode[1]) |=> sweep_done);  // R11
endmodule

bind bn_seq_ctrl bn_seq_ctrl_chk #(
    .NODE_W (NODE_W),
    .DEG_W  (DEG_W),
    .BASE_W (BASE_W),
    .DMAX   (DMAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .msg_we      (msg_we),
    .msg_waddr   (msg_waddr),
    .deg_raddr   (deg_raddr),
    .chan_raddr  (chan_raddr),
    .opnd_ld     (opnd_ld),
    .in_dis      (in_dis),
    .chan_bypass (chan_bypass),
    .sweep_act   (sweep_act),
    .sweep_done  (sweep_done)
);

// File: tb/bn_seq_ctrl_test.sv
module bn_seq_ctrl_test;
    localparam int NODES = 8;
    localparam int DMAX  = 8;
    localparam int LAT   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       first_iter = 1'b0;
    logic       msg_in_vld = 1'b0;
    logic       msg_we;
    logic [6:0] msg_waddr;
    logic [2:0] deg_raddr;
    logic [3:0] deg_rdata = 4'd0;
    logic [2:0] chan_raddr;
    logic       opnd_ld;
    logic [6:0] opnd_base;
    logic [3:0] opnd_cnt;
    logic [7:0] in_dis;
    logic       chan_bypass, sweep_act, sweep_done;
    logic       res_vld, res_post;
    logic [2:0] res_node, res_edge;

    always #10 clk = ~clk;  // 50 MHz

    bn_seq_ctrl #(.NODES(NODES), .DMAX(DMAX), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .first_iter(first_iter),
        .msg_in_vld(msg_in_vld), .msg_we(msg_we), .msg_waddr(msg_waddr),
        .deg_raddr(deg_raddr), .deg_rdata(deg_rdata), .chan_raddr(chan_raddr),
        .opnd_ld(opnd_ld), .opnd_base(opnd_base), .opnd_cnt(opnd_cnt),
        .in_dis(in_dis), .chan_bypass(chan_bypass), .sweep_act(sweep_act),
        .sweep_done(sweep_done), .res_vld(res_vld), .res_post(res_post),
        .res_node(res_node), .res_edge(res_edge)
    );

    // degree RAM model, one-cycle synchronous read
    logic [3:0] deg_mem [NODES];
    always @(posedge clk) deg_rdata <= deg_mem[deg_raddr];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [7:0] dis;
        logic [2:0] chan;
        logic       byp;
        logic [2:0] dra;
        logic       outp;
    } act_t;
    typedef struct packed {
        logic [6:0] base;
        logic [3:0] cnt;
    } ld_t;
    typedef struct packed {
        logic       post;
        logic [2:0] node;
        logic [2:0] edg;
    } res_t;

    act_t act_q[$];
    ld_t  ld_q[$];
    res_t res_q[$];
    int   due_q[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // monitor: scoreboard comparison away from the active edge
    always @(negedge clk) begin : mon
        act_t ea;
        ld_t  el;
        res_t er;
        int   due;
        if (rst_n) begin
            if (opnd_ld) begin
                if (ld_q.size() == 0) chk("R5", "unexpected operand load", 1, 0);
                else begin
                    el = ld_q.pop_front();
                    chk("R5", "operand base", 32'(opnd_base), 32'(el.base));
                    chk("R5", "operand count", 32'(opnd_cnt), 32'(el.cnt));
                end
            end
            if (sweep_act) begin
                if (act_q.size() == 0) chk("R4", "unexpected active cycle", 1, 0);
                else begin
                    ea = act_q.pop_front();
                    chk("R7", "input disable", 32'(in_dis), 32'(ea.dis));
                    chk("R6", "channel address", 32'(chan_raddr), 32'(ea.chan));
                    chk("R8", "bypass", 32'(chan_bypass), 32'(ea.byp));
                    chk("R3", "degree address", 32'(deg_raddr), 32'(ea.dra));
                    if (ea.outp) due_q.push_back(cyc + LAT);
                end
            end else begin
                chk("R3", "degree address when inactive", 32'(deg_raddr), 0);
                chk("R7", "disable when inactive", 32'(in_dis), 0);
            end
            if (res_vld) begin
                if (res_q.size() == 0 || due_q.size() == 0)
                    chk("R10", "unexpected result", 1, 0);
                else begin
                    er  = res_q.pop_front();
                    due = due_q.pop_front();
                    chk("R9", "result post flag", 32'(res_post), 32'(er.post));
                    chk("R4", "result node", 32'(res_node), 32'(er.node));
                    chk("R4", "result edge", 32'(res_edge), 32'(er.edg));
                    chk("R10", "result cycle", 32'(cyc), 32'(due));
                end
            end
        end
    end

    function automatic int clamp(input int d);
        if (d < 2) return 2;
        if (d > DMAX) return DMAX;
        return d;
    endfunction

    // driver: loads degrees, pushes expectations, runs one sweep
    task automatic run_sweep(input bit fin, input bit fi, input logic [3:0] d [NODES]);
        int  base = 0;
        int  waited = 0;
        @(posedge clk); #2;
        mode = 2'd0;
        for (int n = 0; n < NODES; n++) deg_mem[n] = d[n];
        repeat (3) @(posedge clk);
        for (int n = 0; n < NODES; n++) begin
            int dg = clamp(int'(d[n]));
            ld_q.push_back('{base: 7'(base), cnt: 4'(dg)});
            for (int e = 0; e < dg; e++) begin
                bit o = !fin || (e == dg - 1);
                act_q.push_back('{dis: fin ? 8'h00 : 8'(1 << e), chan: 3'(n),
                                  byp: !fin && fi,
                                  dra: (n == NODES - 1) ? 3'd0 : 3'(n + 1), outp: o});
                if (o) res_q.push_back('{post: fin, node: 3'(n), edg: 3'(e)});
            end
            base += dg;
        end
        #2;
        mode = fin ? 2'd3 : 2'd2;
        first_iter = fi;
        @(negedge clk);
        @(negedge clk);
        chk("R3", "priming cycle inactive", 32'(sweep_act), 0);
        @(negedge clk);
        chk("R3", "node 0 starts after priming", 32'(sweep_act), 1);
        while (!sweep_done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk("R11", "done raised", 32'(sweep_done), 1);
        repeat (LAT + 2) begin
            @(negedge clk);
            chk("R11", "done held", 32'(sweep_done), 1);
            chk("R11", "quiet after done", 32'({sweep_act, opnd_ld}), 0);
        end
        chk("R4", "all active cycles issued", act_q.size(), 0);
        chk("R5", "all loads issued", ld_q.size(), 0);
        chk("R10", "all results seen", res_q.size(), 0);
        @(posedge clk); #2;
        mode = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "done clears in idle", 32'(sweep_done), 0);
    endtask

    task automatic recv_burst(input logic [7:0] pat, input int len, input int start);
        int exp = start;
        @(posedge clk); #2;
        mode = 2'd1;
        for (int i = 0; i < len; i++) begin
            msg_in_vld = pat[i];
            #5;
            chk("R1", "write enable", 32'(msg_we), 32'(pat[i]));
            chk("R1", "write address", 32'(msg_waddr), 32'(exp));
            @(posedge clk); #2;
            if (pat[i]) exp++;
        end
        msg_in_vld = 1'b0;
    endtask

    initial begin : wdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual run incomplete, expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [3:0] d1 [NODES] = '{4'd3, 4'd2, 4'd4, 4'd2, 4'd8, 4'd2, 4'd5, 4'd3};
        logic [3:0] d2 [NODES] = '{4'd0, 4'd1, 4'd9, 4'd15, 4'd2, 4'd2, 4'd2, 4'd6};
        logic [3:0] d3 [NODES] = '{4'd2, 4'd3, 4'd2, 4'd7, 4'd2, 4'd4, 4'd2, 4'd2};
        for (int n = 0; n < NODES; n++) deg_mem[n] = 4'd2;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "strobes after reset",
            32'({msg_we, opnd_ld, in_dis, chan_bypass, sweep_act, sweep_done, res_vld}), 0);
        chk("R12", "addresses after reset", 32'({msg_waddr, deg_raddr}), 0);

        // R1 receive pattern, R2 clear in idle
        recv_burst(8'b1011_0101, 8, 0);
        recv_burst(8'b0000_0111, 4, 5);
        @(posedge clk); #2;
        mode = 2'd0;
        msg_in_vld = 1'b1;
        #5;
        chk("R1", "no write in idle", 32'(msg_we), 0);
        @(posedge clk); #2;
        msg_in_vld = 1'b0;
        recv_burst(8'b0000_0011, 3, 0);  // R2: restarts at address 0
        @(posedge clk); #2;
        mode = 2'd0;

        run_sweep(1'b0, 1'b1, d1);  // send, first iteration
        run_sweep(1'b0, 1'b0, d2);  // send, clamped degrees
        run_sweep(1'b1, 1'b1, d3);  // final, first_iter must not bypass
        run_sweep(1'b1, 1'b0, d1);  // final, mixed degrees

        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule